// File: doc/BRIEF.md
# Memory Mapper Upper Page Bit Readback

This block sits on a Z80-style I/O bus next to an existing mapper readback unit that returns only the five low page-number bits. The memory pool is 1 MB, so page numbers need six bits, and the primary mapper registers cannot be read. The block keeps a shadow copy of page bit 5 for each of the four mapper page registers and drives only that bit onto the data bus when software reads a mapper port. It leaves every other data bit undriven.

On the bus, bits 4:0 come from the existing unit, bit 5 comes from this block, and bits 7:6 are pulled up and read as 1. Decode uses /IORQ and /M1 together, so an interrupt-acknowledge cycle never selects the block. The memory-request line plays no part. Bus strobes are sampled on the system clock.

Top module: `mapper_hibit_ext`

## Requirements
- R1: During a qualified read of a mapper port (/IORQ low, /M1 high, /RD low, low address byte 0xFC to 0xFF), `data_oe_o` equals 8'h20 and `data_o[5]` equals the stored bit of the register picked by A1:A0.
- R2: `data_oe_o` never enables any bit other than bit 5, in any cycle.
- R3: A qualified write stores `data_i[5]`, as sampled during the strobe, into the selected register. The new value is visible on reads from the first clock edge at which /WR (or the decode) is sampled inactive. Registers that are not written keep their values.
- R4: A1:A0 selects the register (0xFC is page 0 through 0xFF is page 3). Address bits 15:8 have no effect on decode.
- R5: Accesses whose low address byte lies outside 0xFC to 0xFF neither change any register nor enable the output.
- R6: A cycle with /IORQ and /M1 both low is an interrupt acknowledge. It never enables the output and never changes a register, even when /RD or /WR is low at the same time.
- R7: Reset (`rst_ni` low, asynchronous) clears all four registers to 0.
- R8: `data_oe_o` is combinational from the strobes. It is zero in the same cycle that /RD goes high.
- R9: On the pulled-up bus shared with the five-bit unit, a mapper read returns {2'b11, stored bit 5, written bits 4:0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the bus strobes |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | I/O address bus |
| data_i | input | 8 | Data bus as seen on writes |
| iorq_ni | input | 1 | I/O request, active low |
| m1_ni | input | 1 | Opcode fetch / interrupt acknowledge marker, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| data_o | output | 8 | Read data, only bit 5 meaningful |
| data_oe_o | output | 8 | Per-bit output enable for the tri-state driver |

## Verification
The bench builds the block with its default parameters: 16-bit address, 8-bit data, four pages based at 0xFC, and extension bit 5. With these values every page number from 0 to 63 can be written to every port and read back across the combined pulled-up bus. The bench also aliases ports through the upper address byte, uses the neighbouring port 0xFB, and runs interrupt-acknowledge cycles with glitched strobes against the exact port range. Reset is applied again in mid-run, after the registers have been set, to show that they clear.

// File: rtl/mapper_hibit_pkg.sv
package mapper_hibit_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_RD   = 2'd1,
    CYC_WR   = 2'd2,
    CYC_INTA = 2'd3
  } bus_cyc_e;
endpackage

// File: rtl/mapper_io_qual.sv
module mapper_io_qual
  import mapper_hibit_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DEC_W     = 8,
  parameter int SEL_W     = 2,
  parameter logic [7:0] PORT_BASE = 8'hFC
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              iorq_ni,
  input  logic              m1_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  output bus_cyc_e          cyc_o,
  output logic              hit_o,
  output logic [SEL_W-1:0]  sel_o
);
  localparam int TAG_W = DEC_W - SEL_W;
  localparam logic [TAG_W-1:0] TAG = PORT_BASE[DEC_W-1:SEL_W];

  // upper address byte deliberately left out of the compare
  assign hit_o = (addr_i[DEC_W-1:SEL_W] == TAG);
  assign sel_o = addr_i[SEL_W-1:0];

  always_comb begin
    cyc_o = CYC_IDLE;
    if (!iorq_ni) begin
      if (!m1_ni)      cyc_o = CYC_INTA;
      else if (!rd_ni) cyc_o = CYC_RD;
      else if (!wr_ni) cyc_o = CYC_WR;
    end
  end
endmodule

// File: rtl/mapper_bit_store.sv
module mapper_bit_store #(
  parameter int PAGE_CNT = 4,
  parameter int SEL_W    = $clog2(PAGE_CNT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_act_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic             wr_bit_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic             rd_bit_o
);
  logic             wr_q;
  logic [SEL_W-1:0] sel_q;
  logic             bit_q;
  logic [PAGE_CNT-1:0] page_q;
  logic             commit;

  assign commit = wr_q && !wr_act_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= 1'b0;
      sel_q <= '0;
      bit_q <= 1'b0;
    end else begin
      wr_q <= wr_act_i;
      if (wr_act_i) begin
        sel_q <= wr_sel_i;
        bit_q <= wr_bit_i;
      end
    end
  end

  for (genvar g = 0; g < PAGE_CNT; g++) begin : g_page
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   page_q[g] <= 1'b0;
      else if (commit && (sel_q == SEL_W'(g)))       page_q[g] <= bit_q;
    end
  end

  assign rd_bit_o = page_q[rd_sel_i];

  // R3: nothing changes without a write ending
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(page_q));
  // R3: the ending write lands in the selected page
  p_commit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> page_q[$past(sel_q)] == $past(bit_q));
endmodule

// File: rtl/mapper_hibit_ext.sv
module mapper_hibit_ext
  import mapper_hibit_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int PAGE_CNT = 4,
  parameter int EXT_BIT  = 5,
  parameter logic [7:0] PORT_BASE = 8'hFC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              iorq_ni,
  input  logic              m1_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] data_oe_o
);
  localparam int SEL_W = $clog2(PAGE_CNT);
  localparam int DEC_W = 8;
  localparam logic [DATA_W-1:0] EXT_MASK = DATA_W'(1) << EXT_BIT;

  bus_cyc_e         cyc;
  logic             hit;
  logic [SEL_W-1:0] sel;
  logic             rd_bit;
  logic             rd_act, wr_act;

  mapper_io_qual #(
    .ADDR_W(ADDR_W), .DEC_W(DEC_W), .SEL_W(SEL_W), .PORT_BASE(PORT_BASE)
  ) u_qual (
    .addr_i(addr_i), .iorq_ni(iorq_ni), .m1_ni(m1_ni),
    .rd_ni(rd_ni), .wr_ni(wr_ni),
    .cyc_o(cyc), .hit_o(hit), .sel_o(sel)
  );

  assign rd_act = hit && (cyc == CYC_RD);
  assign wr_act = hit && (cyc == CYC_WR);

  mapper_bit_store #(.PAGE_CNT(PAGE_CNT), .SEL_W(SEL_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_act_i(wr_act), .wr_sel_i(sel), .wr_bit_i(data_i[EXT_BIT]),
    .rd_sel_i(sel), .rd_bit_o(rd_bit)
  );

  assign data_oe_o = rd_act ? EXT_MASK : '0;
  assign data_o    = rd_bit ? EXT_MASK : '0;

  // R2: only the extension bit may ever be driven
  p_oe_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o & ~EXT_MASK) == '0);
  // R6: interrupt acknowledge never drives the bus
  p_inta_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iorq_ni && !m1_ni) |-> data_oe_o == '0);
  // R8: enable only inside an active read strobe
  p_oe_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|data_oe_o) |-> (!rd_ni && !iorq_ni && m1_ni));
  // R5: ports outside the window stay silent
  p_miss_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[DEC_W-1:SEL_W] != PORT_BASE[DEC_W-1:SEL_W]) |-> data_oe_o == '0);
endmodule

// File: tb/mapper_hibit_ext_bench.sv
module mapper_hibit_ext_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0;
  logic [7:0]  din = 8'h0;
  logic        iorq_n = 1'b1, m1_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0]  dout, doe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model: shadow bit 5 and the existing five-bit unit
  int hi_mdl[4];
  int lo_mdl[4];
  int pend_v = 0, pend_sel = 0, pend_dat = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mapper_hibit_ext u_mapper_hibit_ext (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(din),
    .iorq_ni(iorq_n), .m1_ni(m1_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .data_o(dout), .data_oe_o(doe)
  );

  function automatic bit port_hit();
    return addr[7:0] >= 8'hFC;
  endfunction
  function automatic bit q_read();
    return !iorq_n && m1_n && !rd_n && port_hit();
  endfunction
  function automatic bit q_write();
    return !iorq_n && m1_n && rd_n && !wr_n && port_hit();
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin hi_mdl[i] = 0; lo_mdl[i] = 0; end
      pend_v = 0;
    end else if (q_write()) begin
      pend_v = 1; pend_sel = int'(addr[1:0]); pend_dat = int'(din);
    end else if (pend_v != 0) begin
      hi_mdl[pend_sel] = (pend_dat >> 5) & 1;
      lo_mdl[pend_sel] = pend_dat & 31;
      pend_v = 0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison of enable and driven bit against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R1/R2/R5/R6/R8 oe", int'(doe), q_read() ? 32'h20 : 0);
      if (q_read()) check("R1 bit5", int'(dout[5]), hi_mdl[addr[1:0]]);
    end
  end

  function automatic logic [7:0] bus_value();
    logic [7:0] b;
    for (int i = 0; i < 8; i++) begin
      if (doe[i]) b[i] = dout[i];
      else if (q_read() && i < 5) b[i] = lo_mdl[addr[1:0]][i];
      else b[i] = 1'b1;
    end
    return b;
  endfunction

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    addr = a; din = d; iorq_n = 0; m1_n = 1; wr_n = 0;
    @(negedge clk); #1;
    wr_n = 1; iorq_n = 1;
  endtask

  task automatic io_read(input logic [15:0] a, input int exp, input string req);
    @(negedge clk); #1;
    addr = a; iorq_n = 0; m1_n = 1; rd_n = 0;
    #1 check(req, int'(bus_value()), exp);
    @(negedge clk); #1;
    rd_n = 1; iorq_n = 1;
    #1 check("R8 oe off after read", int'(doe), 0);
  endtask

  task automatic inta(input logic [15:0] a, input logic [7:0] d, input bit glitch_rd);
    @(negedge clk); #1;
    addr = a; din = d; iorq_n = 0; m1_n = 0; wr_n = 0; rd_n = !glitch_rd;
    #1 check("R6 inta oe", int'(doe), 0);
    @(negedge clk); #1;
    iorq_n = 1; m1_n = 1; wr_n = 1; rd_n = 1;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R7: reset state
    for (int p = 0; p < 4; p++) io_read(16'h00FC + 16'(p), 8'hC0, "R7 reset clear");
    // R3 R9: every page number on every port
    for (int p = 0; p < 4; p++)
      for (int v = 0; v < 64; v++) begin
        io_write(16'h00FC + 16'(p), 8'(v));
        io_read(16'h00FC + 16'(p), 8'hC0 | v, "R9/R3 readback");
      end
    // R4: upper address byte is ignored, A1:A0 select
    io_write(16'h00FC, 8'h00); io_write(16'h00FD, 8'h00);
    io_write(16'h00FE, 8'h00); io_write(16'h00FF, 8'h00);
    io_write(16'hA5FE, 8'h21);
    io_read(16'h3CFE, 8'hE1, "R4 alias write/read");
    io_read(16'h00FD, 8'hC0, "R4 other page untouched");
    io_read(16'h00FF, 8'hC0, "R3 unwritten page keeps value");
    // R5: neighbouring port is ignored
    io_write(16'h00FB, 8'h3F);
    io_write(16'h00FC, 8'h20);
    io_write(16'h00F8, 8'h00);
    io_read(16'h00FC, 8'hE0, "R5 write outside window ignored");
    io_read(16'h00FB, 8'hFF, "R5 read outside window undriven");
    // R6: interrupt acknowledge with glitched strobes
    inta(16'h00FC, 8'h00, 1'b1);
    inta(16'h00FD, 8'h3F, 1'b0);
    io_read(16'h00FC, 8'hE0, "R6 inta no write p0");
    io_read(16'h00FD, 8'hC0, "R6 inta no write p1");
    // R7: reset again after setting all pages
    for (int p = 0; p < 4; p++) io_write(16'h00FC + 16'(p), 8'h20);
    io_read(16'h00FF, 8'hE0, "R3 set before reset");
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    for (int p = 0; p < 4; p++) io_read(16'h00FC + 16'(p), 8'hC0, "R7 mid-run reset");
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule